// File: doc/BRIEF.md
# Shared-Clock Tick Distribution Controller

This block is the master side of a time-triggered scheme in which one node owns the time base and all other nodes follow it. A local down-counting timer marks the end of each tick period. At every expiry the block starts a tick round. It raises a one-cycle strobe for the master's own tasks and pushes tick messages to a set of slave nodes. The network has no broadcast, so every tick goes out on its own point-to-point send strobe, one strobe line per slave. Each slave answers with an acknowledgement pulse, and the block records which slaves answered and which stayed silent.

Three distribution policies can be selected. The first is acknowledged sequential: a slave receives its tick only after the slave before it has answered or timed out. The second is back-to-back round-robin: the sends go out in consecutive cycles and the answers are gathered afterwards. The third is tree forwarding: the master sends only to the slaves marked as tree roots, those slaves pass the tick on to their children, and the master waits for answers from every slave. If the timer expires while a round is still running, that round carries on, the new round is dropped and a sticky overrun flag is set.

Top module: `tick_master`

## Requirements
- R1: `tick_start` is a one-cycle pulse. When no overrun occurs, consecutive pulses lie exactly `reload_val`+1 cycles apart.
- R2: Policy code 0 (or 3) is acknowledged sequential. `send_tick` is one-hot, slaves are served from index 0 upward, slave 0 is sent in the `tick_start` cycle, and slave k+1 is sent exactly one cycle after the cycle in which slave k's ACK was sampled.
- R3: In the sequential policy, a slave sent in cycle S that has no ACK by cycle S+`ack_timeout`+1 gets its sticky `ack_err` bit set, and the next slave is sent in cycle S+`ack_timeout`+2. An ACK in cycle S+`ack_timeout`+1 is still accepted.
- R4: Policy code 1 is round-robin. Slaves 0 to N-1 are each sent once, one-hot, in N consecutive cycles starting with the `tick_start` cycle.
- R5: Policy code 2 is tree forwarding. In the `tick_start` cycle, `send_tick` equals `tree_roots` for that single cycle, and ACKs are then expected from all slaves.
- R6: `ack_seen[i]` is set by `ack_in[i]` only while slave i has been sent to and has not yet answered or expired. An ACK from a slave that has not been sent to is ignored. `ack_seen` clears when a round starts.
- R7: In the round-robin and tree policies, ACK collection starts the cycle after the last send and lasts at most `ack_timeout`+1 cycles. Slaves still unacknowledged at the end get their `ack_err` bit set. The round ends early once every ACK is in.
- R8: A timer expiry while a round is running sets the sticky `overrun` flag and starts no round and no `tick_start`.
- R9: While reset is held, all outputs are zero.
- R10: `busy` is high from the `tick_start` cycle through the last cycle of the round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy | input | 2 | Distribution policy: 0/3 sequential, 1 round-robin, 2 tree; sampled at round start |
| reload_val | input | TMR_W | Timer reload; period is reload_val+1 cycles |
| ack_timeout | input | TO_W | ACK wait limit in cycles (window is ack_timeout+1) |
| tree_roots | input | N_SLV | Slaves the master sends to directly under the tree policy |
| ack_in | input | N_SLV | Per-slave acknowledgement pulses |
| tick_start | output | 1 | One-cycle strobe at round start for local tasks |
| send_tick | output | N_SLV | Per-slave point-to-point tick send strobes |
| ack_seen | output | N_SLV | Slaves that acknowledged in the current or last round |
| ack_err | output | N_SLV | Sticky per-slave missed-ACK flags |
| overrun | output | 1 | Sticky flag: the timer expired during a running round |
| busy | output | 1 | A tick round is in progress |

## Verification
The hardest situation to reach from the ports is an ACK that arrives at the exact edge of the timeout window, in the same cycle as the decision to give up on that slave. The bench models each slave as a responder with a programmable delay counted from the cycle its tick was observed. With delays of `ack_timeout`+1 and `ack_timeout`+2 it places one ACK in the last accepted cycle and one in the first late cycle. An overrun is forced by combining a short reload with silent slaves, so that the sequential timeouts stretch the round past one timer period.

// File: rtl/tick_pkg.sv
// Shared types for the tick distribution controller.
// Assumes: policy code 3 is treated the same as code 0.
package tick_pkg;
    typedef enum logic [1:0] {
        POL_SEQ     = 2'd0,
        POL_RR      = 2'd1,
        POL_TREE    = 2'd2,
        POL_SEQ_ALT = 2'd3
    } policy_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SEND    = 2'd1,
        ST_WAITONE = 2'd2,
        ST_WAITALL = 2'd3
    } round_st_e;
endpackage

// File: rtl/tick_timer.sv
// Period timer: counts down from reload_val and flags expiry while the count is zero.
// Assumes: reload_val is sampled at each reload, so a change takes effect on the next period.
module tick_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] reload_val,
    output logic             expired
);
    logic [TMR_W-1:0] cnt_q;

    // Down-count with reload at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= reload_val;
        else if (cnt_q == '0)    cnt_q <= reload_val;
        else                     cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R1: after expiry the counter restarts from the reload value
    p_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> (cnt_q == $past(reload_val)));
endmodule

// File: rtl/ack_tracker.sv
// Per-slave ACK bookkeeping: pending, seen and sticky error bits.
// Assumes: arm, expire and clear come from the round sequencer. An ACK has priority over expiry.
module ack_tracker #(
    parameter int N_SLV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [N_SLV-1:0] arm,
    input  logic [N_SLV-1:0] expire,
    input  logic [N_SLV-1:0] ack_in,
    output logic [N_SLV-1:0] pend,
    output logic [N_SLV-1:0] seen,
    output logic [N_SLV-1:0] err
);
    for (genvar i = 0; i < N_SLV; i++) begin : g_slv
        // Per-slave state update: arm, accept ACK, or expire.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
                seen[i] <= 1'b0;
                err[i]  <= 1'b0;
            end else if (clear) begin
                pend[i] <= 1'b0;
                seen[i] <= 1'b0;
            end else if (arm[i]) begin
                pend[i] <= 1'b1;
            end else if (pend[i] && ack_in[i]) begin
                pend[i] <= 1'b0;
                seen[i] <= 1'b1;
            end else if (pend[i] && expire[i]) begin
                pend[i] <= 1'b0;
                err[i]  <= 1'b1;
            end
        end

        // R3 / R7: a missed-ACK flag never clears outside reset
        p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
            err[i] |=> err[i]);
        // R6: seen only rises after an ACK on a pending slave
        p_seen_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(seen[i]) |-> $past(pend[i] && ack_in[i]));
    end
endmodule

// File: rtl/tick_master.sv
// Master of a shared-clock tick scheme over point-to-point links.
// Each timer expiry starts a round that sends ticks under the selected policy
// and collects per-slave ACKs with a timeout.
// Assumes: ack_timeout and tree_roots stay stable during a round. Policy is latched at round start.
module tick_master
    import tick_pkg::*;
#(
    parameter int N_SLV = 4,
    parameter int TMR_W = 16,
    parameter int TO_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       policy,
    input  logic [TMR_W-1:0] reload_val,
    input  logic [TO_W-1:0]  ack_timeout,
    input  logic [N_SLV-1:0] tree_roots,
    input  logic [N_SLV-1:0] ack_in,
    output logic             tick_start,
    output logic [N_SLV-1:0] send_tick,
    output logic [N_SLV-1:0] ack_seen,
    output logic [N_SLV-1:0] ack_err,
    output logic             overrun,
    output logic             busy
);
    localparam int IDX_W = (N_SLV > 1) ? $clog2(N_SLV) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SLV - 1);

    round_st_e        st_q;
    policy_e          pol_q;
    logic [IDX_W-1:0] idx_q;
    logic [TO_W-1:0]  tcnt_q;
    logic             start_q;
    logic             ovr_q;
    logic             tmr_exp;
    logic             round_go;
    logic             is_seq;
    logic             timed_out;
    logic             ack_cur;
    logic             all_in;
    logic [N_SLV-1:0] arm;
    logic [N_SLV-1:0] expire;
    logic [N_SLV-1:0] pend;
    logic [N_SLV-1:0] cur_bit;

    tick_timer #(.TMR_W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload_val (reload_val),
        .expired    (tmr_exp)
    );

    ack_tracker #(.N_SLV(N_SLV)) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (round_go),
        .arm    (arm),
        .expire (expire),
        .ack_in (ack_in),
        .pend   (pend),
        .seen   (ack_seen),
        .err    (ack_err)
    );

    assign round_go  = tmr_exp && (st_q == ST_IDLE);
    assign is_seq    = (pol_q == POL_SEQ) || (pol_q == POL_SEQ_ALT);
    assign timed_out = (tcnt_q == ack_timeout);
    assign cur_bit   = N_SLV'(1) << idx_q;
    assign ack_cur   = |(pend & ack_in & cur_bit);
    assign all_in    = ((pend & ~ack_in) == '0);

    // Send strobes and tracker arming for the current send slot.
    always_comb begin
        send_tick = '0;
        arm       = '0;
        if (st_q == ST_SEND) begin
            if (pol_q == POL_TREE) begin
                send_tick = tree_roots;
                arm       = '1;
            end else begin
                send_tick = cur_bit;
                arm       = cur_bit;
            end
        end
    end

    // Expiry mask handed to the tracker when a wait window runs out.
    always_comb begin
        expire = '0;
        if (timed_out) begin
            if (st_q == ST_WAITONE)      expire = cur_bit;
            else if (st_q == ST_WAITALL) expire = '1;
        end
    end

    // Round sequencer: start, send slots, ACK waits, overrun detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            pol_q   <= POL_SEQ;
            idx_q   <= '0;
            tcnt_q  <= '0;
            start_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            start_q <= round_go;
            if (tmr_exp && st_q != ST_IDLE) ovr_q <= 1'b1;
            case (st_q)
                ST_IDLE: begin
                    if (tmr_exp) begin
                        st_q  <= ST_SEND;
                        idx_q <= '0;
                        pol_q <= policy_e'(policy);
                    end
                end
                ST_SEND: begin
                    tcnt_q <= '0;
                    if (pol_q == POL_TREE)  st_q <= ST_WAITALL;
                    else if (is_seq)        st_q <= ST_WAITONE;
                    else if (idx_q == LAST) st_q <= ST_WAITALL;
                    else                    idx_q <= idx_q + 1'b1;
                end
                ST_WAITONE: begin
                    if (ack_cur || timed_out) begin
                        if (idx_q == LAST) st_q <= ST_IDLE;
                        else begin
                            idx_q <= idx_q + 1'b1;
                            st_q  <= ST_SEND;
                        end
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                ST_WAITALL: begin
                    if (all_in || timed_out) st_q <= ST_IDLE;
                    else                     tcnt_q <= tcnt_q + 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign tick_start = start_q;
    assign overrun    = ovr_q;
    assign busy       = (st_q != ST_IDLE);

    // R1: the start strobe lasts exactly one cycle
    p_start_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_start |=> !tick_start);
    // R2: sequential and round-robin rounds send to at most one slave per cycle
    p_seq_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_q != POL_TREE) |-> $onehot0(send_tick));
    // R4: round-robin sends do not pause before the last slave
    p_rr_back_to_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SEND && pol_q == POL_RR && idx_q != LAST) |=> (st_q == ST_SEND));
    // R8: overrun only rises after a timer expiry during a running round
    p_overrun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(busy && tmr_exp));
    // R10: a round is running whenever the start strobe is high
    p_busy_on_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_start |-> busy);
endmodule

// File: tb/tick_master_tb.sv
// Directed bench for tick_master: slaves are modelled as delayed ACK responders.
module tick_master_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   policy = 2'd0;
    logic [15:0]  reload_val = 16'd200;
    logic [7:0]   ack_timeout = 8'd5;
    logic [N-1:0] tree_roots = '0;
    logic [N-1:0] ack_in = '0;
    logic         tick_start;
    logic [N-1:0] send_tick;
    logic [N-1:0] ack_seen;
    logic [N-1:0] ack_err;
    logic         overrun;
    logic         busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int dly [N];
    int due [N];
    int send_cyc [N];
    int send_cnt [N];
    int ts_cyc [4];
    int ts_cnt = 0;
    int busy_fall = -1;
    int bad_onehot = 0;
    int bad_start = 0;
    int spur_at = -10;
    bit spur_en = 1'b0;
    bit tree_mode = 1'b0;
    bit prev_busy = 1'b0;
    logic [N-1:0] seen_probe = '0;

    always #4 clk = ~clk;

    tick_master #(.N_SLV(N), .TMR_W(16), .TO_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .policy(policy), .reload_val(reload_val),
        .ack_timeout(ack_timeout), .tree_roots(tree_roots), .ack_in(ack_in),
        .tick_start(tick_start), .send_tick(send_tick), .ack_seen(ack_seen),
        .ack_err(ack_err), .overrun(overrun), .busy(busy)
    );

    // Monitor and slave responder, sampling at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            for (int i = 0; i < N; i++) begin
                if (send_tick[i]) begin
                    send_cnt[i]++;
                    send_cyc[i] = cyc;
                    if (tree_mode) begin
                        for (int j = 0; j < N; j++)
                            if (dly[j] != 0) due[j] = cyc + dly[j];
                    end else if (dly[i] != 0) begin
                        due[i] = cyc + dly[i];
                    end
                end
            end
            if (tick_start) begin
                if (prev_busy) bad_start++;
                if (ts_cnt < 4) ts_cyc[ts_cnt] = cyc;
                ts_cnt++;
                if (spur_en) spur_at = cyc + 1;
            end
            for (int i = 0; i < N; i++)
                ack_in[i] = (due[i] == cyc) || (spur_en && i == 2 && cyc == spur_at);
            if (!tree_mode && $countones(send_tick) > 1) bad_onehot++;
            if (prev_busy && !busy) busy_fall = cyc;
            if (cyc == spur_at + 1) seen_probe = ack_seen;
            prev_busy = busy;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_ts(input int n);
        while (ts_cnt < n) step(1);
    endtask

    task automatic do_reset(input int d0, input int d1, input int d2, input int d3);
        rst_n = 1'b0;
        dly[0] = d0; dly[1] = d1; dly[2] = d2; dly[3] = d3;
        for (int i = 0; i < N; i++) begin
            due[i] = -1; send_cyc[i] = -1; send_cnt[i] = 0;
        end
        ts_cnt = 0; busy_fall = -1; bad_onehot = 0; bad_start = 0;
        spur_en = 1'b0; spur_at = -10; tree_mode = 1'b0;
        step(3);
        rst_n = 1'b1;
    endtask

    // R9: reset state of every output
    task automatic t_reset();
        rst_n = 1'b0;
        step(3);
        chk(tick_start == 1'b0, "R9 tick_start", tick_start, 0);
        chk(send_tick == '0, "R9 send_tick", send_tick, 0);
        chk(ack_seen == '0, "R9 ack_seen", ack_seen, 0);
        chk(ack_err == '0, "R9 ack_err", ack_err, 0);
        chk(overrun == 1'b0, "R9 overrun", overrun, 0);
        chk(busy == 1'b0, "R9 busy", busy, 0);
    endtask

    // R2 / R6: sequential policy with a spurious early ACK on slave 2
    task automatic t_sequential();
        policy = 2'd0; reload_val = 16'd200; ack_timeout = 8'd5;
        do_reset(3, 1, 2, 4);
        spur_en = 1'b1;
        wait_ts(1);
        step(60);
        chk(send_cyc[0] == ts_cyc[0], "R2 first send", send_cyc[0], ts_cyc[0]);
        chk(send_cyc[1] == send_cyc[0] + 4, "R2 send1", send_cyc[1], send_cyc[0] + 4);
        chk(send_cyc[2] == send_cyc[1] + 2, "R2 send2", send_cyc[2], send_cyc[1] + 2);
        chk(send_cyc[3] == send_cyc[2] + 3, "R2 send3", send_cyc[3], send_cyc[2] + 3);
        chk(bad_onehot == 0, "R2 onehot", bad_onehot, 0);
        chk(seen_probe[2] == 1'b0, "R6 spurious ack ignored", seen_probe[2], 0);
        chk(ack_seen == 4'hF, "R6 seen", ack_seen, 15);
        chk(ack_err == 4'h0, "R3 no err", ack_err, 0);
    endtask

    // R3: timeouts in the sequential policy, with ACKs at and after the window edge
    task automatic t_seq_timeout();
        policy = 2'd3; reload_val = 16'd200; ack_timeout = 8'd5;
        do_reset(0, 6, 7, 2);
        wait_ts(1);
        step(60);
        chk(send_cyc[1] == send_cyc[0] + 7, "R3 advance after timeout", send_cyc[1], send_cyc[0] + 7);
        chk(send_cyc[2] == send_cyc[1] + 7, "R3 edge ack", send_cyc[2], send_cyc[1] + 7);
        chk(send_cyc[3] == send_cyc[2] + 7, "R3 late ack", send_cyc[3], send_cyc[2] + 7);
        chk(ack_err == 4'b0101, "R3 err", ack_err, 5);
        chk(ack_seen == 4'b1010, "R6 seen timeout", ack_seen, 10);
    endtask

    // R4 / R7: round-robin with one ACK beyond the collection window
    task automatic t_round_robin();
        policy = 2'd1; reload_val = 16'd200; ack_timeout = 8'd5;
        do_reset(2, 5, 9, 3);
        wait_ts(1);
        step(60);
        for (int i = 0; i < N; i++)
            chk(send_cyc[i] == ts_cyc[0] + i && send_cnt[i] == 1, "R4 rr slot", send_cyc[i], ts_cyc[0] + i);
        chk(bad_onehot == 0, "R4 onehot", bad_onehot, 0);
        chk(ack_seen == 4'b1011, "R7 seen", ack_seen, 11);
        chk(ack_err == 4'b0100, "R7 err", ack_err, 4);
        chk(busy_fall == ts_cyc[0] + 10, "R10 busy end", busy_fall, ts_cyc[0] + 10);
    endtask

    // R5 / R7: tree forwarding with a silent leaf
    task automatic t_tree();
        policy = 2'd2; reload_val = 16'd200; ack_timeout = 8'd5;
        tree_roots = 4'b0011;
        do_reset(1, 2, 3, 0);
        tree_mode = 1'b1;
        wait_ts(1);
        step(60);
        chk(send_cyc[0] == ts_cyc[0] && send_cyc[1] == ts_cyc[0], "R5 roots sent", send_cyc[1], ts_cyc[0]);
        chk(send_cnt[0] == 1 && send_cnt[2] == 0 && send_cnt[3] == 0, "R5 only roots once", send_cnt[2] + send_cnt[3], 0);
        chk(ack_seen == 4'b0111, "R5 seen all but leaf", ack_seen, 7);
        chk(ack_err == 4'b1000, "R7 tree err", ack_err, 8);
        chk(busy_fall == ts_cyc[0] + 7, "R7 window end", busy_fall, ts_cyc[0] + 7);
    endtask

    // R1: tick period with fast ACKs
    task automatic t_period();
        policy = 2'd0; reload_val = 16'd20; ack_timeout = 8'd5;
        do_reset(1, 1, 1, 1);
        wait_ts(2);
        chk(ts_cyc[1] - ts_cyc[0] == 21, "R1 period", ts_cyc[1] - ts_cyc[0], 21);
        chk(overrun == 1'b0, "R8 no overrun", overrun, 0);
    endtask

    // R8 / R10: silent slaves stretch the round past one period
    task automatic t_overrun();
        policy = 2'd0; reload_val = 16'd20; ack_timeout = 8'd5;
        do_reset(0, 0, 0, 0);
        wait_ts(2);
        chk(ts_cyc[1] - ts_cyc[0] == 42, "R8 skipped round", ts_cyc[1] - ts_cyc[0], 42);
        chk(overrun == 1'b1, "R8 overrun flag", overrun, 1);
        chk(bad_start == 0, "R10 no start while busy", bad_start, 0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_sequential();
        t_seq_timeout();
        t_round_robin();
        t_tree();
        t_period();
        t_overrun();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule